// File: doc/BRIEF.md
# Reset and Exception Entry Sequencer

This block redirects control flow for a 32-bit processor core. It handles power-on reset, manual reset, TLB multiple-hit reset, general exceptions, trap instructions, TLB exceptions and accepted interrupts. The core raises a single-cycle request. With that request it presents the current PC, status register, R15, vector base, page-table-entry-high register and faulting address. Each request class that carries a cause also carries its own code.

On the next clock edge the block registers one update bundle. The bundle holds a new PC and next-PC, the saved PC/status/stack values, a new status register, and a VBR clear strobe. It also holds the values for the cause registers: the exception event code, the interrupt event code, the trap operand, the TLB fault address and the page-table high word. Each field comes with its own write strobe for the register file around the block. When no request arrives, every strobe is low and every value field is zero.

Status register bit positions used throughout: T=0, S=1, IMASK=7:4, Q=8, M=9, FD=15, BL=28, RB=29, MD=30. The implemented-bit mask is 0x700083F3.

Top module: `exc_entry_seq`

## Requirements
- R1: While rst_n is low, and one cycle after a por_req, the outputs carry the power-on image. This is pc_o=0xA0000000, npc_o=0xA0000002, vbr_clr=1, sr_o=0x700000F0 with sr_we=1, fpscr_o=0x00040001 with fpscr_we=1, expevt_o=0x000 with expevt_we=1, and ssave_we=0.
- R2: A manual reset (code 0x020) or a TLB multiple-hit reset (code 0x140) gives pc_o=0xA0000000, npc_o=0xA0000002 and vbr_clr=1. It gives sr_o=((cur_sr | MD | BL | RB | IMASK) & ~FD) masked to the implemented bits. Its code goes to expevt_o, and nothing is saved (ssave_we=0).
- R3: A general exception that arrives while cur_sr bit BL is 1 is handled exactly as a manual reset, with code 0x020. No state is saved.
- R4: A normal exception, trap, TLB exception or interrupt sets ssave_we. It gives spc_o=cur_pc, ssr_o=cur_sr masked to the implemented bits, and sgr_o=cur_r15. It gives sr_o=(cur_sr | MD | BL | RB) masked.
- R5: General exceptions and traps target cur_vbr+0x100. TLB exceptions target cur_vbr+0x400. Interrupts target cur_vbr+0x600. npc_o is always pc_o+2.
- R6: A trap gives tra_o = trap_imm shifted left by 2 and zero-extended, with tra_we=1. It writes expevt_o=0x160.
- R7: A TLB exception or multiple-hit reset gives tea_o=fault_addr. It gives pteh_o with bits 31:10 taken from fault_addr and bits 9:0 taken from cur_pteh. A TLB exception writes tlb_code to expevt_o.
- R8: An interrupt writes irq_code to intevt_o with intevt_we=1, and leaves expevt_we low.
- R9: Requests in the same cycle resolve in this order: power-on, multiple-hit, manual reset (including a converted exception), general exception, TLB exception, trap, interrupt. Exactly one update is applied.
- R10: Each update appears on the outputs in the cycle after its request, and back-to-back requests give back-to-back updates. With no request, all write strobes are low.
- R11: Bits of sr_o and ssr_o outside the mask 0x700083F3 are always zero.
- R12: dslot_clr is asserted together with every update, telling the core to drop its delay-slot state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; holds the power-on image |
| por_req | input | 1 | Power-on reset request pulse |
| mhit_req | input | 1 | TLB multiple-hit reset request pulse |
| mrst_req | input | 1 | Manual reset request pulse |
| exc_req | input | 1 | General exception request pulse |
| tlb_req | input | 1 | TLB exception request pulse |
| trap_req | input | 1 | Trap instruction request pulse |
| irq_req | input | 1 | Accepted interrupt request pulse |
| exc_code | input | 12 | Event code for a general exception |
| tlb_code | input | 12 | Event code for a TLB exception |
| irq_code | input | 12 | Interrupt event code from the interrupt controller |
| trap_imm | input | 8 | Trap immediate operand |
| cur_pc | input | 32 | Current PC |
| cur_sr | input | 32 | Current assembled status register |
| cur_r15 | input | 32 | Current R15 |
| cur_vbr | input | 32 | Current vector base |
| cur_pteh | input | 32 | Current page-table-entry-high register |
| fault_addr | input | 32 | Faulting virtual address |
| pc_we | output | 1 | PC and next-PC write strobe |
| pc_o | output | 32 | New PC |
| npc_o | output | 32 | New next-PC |
| dslot_clr | output | 1 | Clear delay-slot state |
| sr_we | output | 1 | Status register write strobe |
| sr_o | output | 32 | New status register |
| ssave_we | output | 1 | Saved PC/SR/R15 write strobe |
| spc_o | output | 32 | Saved PC value |
| ssr_o | output | 32 | Saved status value |
| sgr_o | output | 32 | Saved R15 value |
| vbr_clr | output | 1 | Clear the vector base to zero |
| fpscr_we | output | 1 | Floating-point control write strobe |
| fpscr_o | output | 32 | Floating-point control value |
| expevt_we | output | 1 | Exception event register write strobe |
| expevt_o | output | 12 | Exception event code |
| intevt_we | output | 1 | Interrupt event register write strobe |
| intevt_o | output | 12 | Interrupt event code |
| tra_we | output | 1 | Trap operand register write strobe |
| tra_o | output | 32 | Trap operand value |
| tea_we | output | 1 | TLB fault address write strobe |
| tea_o | output | 32 | TLB fault address value |
| pteh_we | output | 1 | Page-table high word write strobe |
| pteh_o | output | 32 | Merged page-table high word |

## Verification
The bench targets the BL-set exception. A design that missed the conversion would save state and jump to the vector base instead of returning to 0xA0000000. It checks that a manual reset clears FD while an ordinary entry keeps it. Either mistake would show up as a wrong sr_o bit 15. Same-cycle request mixes are applied at every priority boundary, so a swapped rank would emit the lower event's code and target. The page-table merge and the SR/SSR masking are checked with values whose low and unimplemented bits are non-zero. This exposes a merge that takes the wrong half, or an unmasked copy. Interrupt entry is checked to leave the exception event code untouched.

// File: rtl/exc_entry_pkg.sv
`timescale 1ns/1ps
package exc_entry_pkg;

    localparam int WORD_W = 32;

    // status register bit positions
    localparam int SR_T_BIT  = 0;
    localparam int SR_S_BIT  = 1;
    localparam int SR_IM_LO  = 4;
    localparam int SR_IM_HI  = 7;
    localparam int SR_Q_BIT  = 8;
    localparam int SR_M_BIT  = 9;
    localparam int SR_FD_BIT = 15;
    localparam int SR_BL_BIT = 28;
    localparam int SR_RB_BIT = 29;
    localparam int SR_MD_BIT = 30;

    localparam logic [WORD_W-1:0] SR_IMPL_MASK =
        (WORD_W'(1) << SR_T_BIT)  | (WORD_W'(1) << SR_S_BIT)  |
        (WORD_W'(4'hF) << SR_IM_LO) |
        (WORD_W'(1) << SR_Q_BIT)  | (WORD_W'(1) << SR_M_BIT)  |
        (WORD_W'(1) << SR_FD_BIT) | (WORD_W'(1) << SR_BL_BIT) |
        (WORD_W'(1) << SR_RB_BIT) | (WORD_W'(1) << SR_MD_BIT);

    localparam logic [WORD_W-1:0] SR_ENTRY_SET =
        (WORD_W'(1) << SR_MD_BIT) | (WORD_W'(1) << SR_BL_BIT) |
        (WORD_W'(1) << SR_RB_BIT);

    localparam logic [WORD_W-1:0] SR_IMASK_ALL = WORD_W'(4'hF) << SR_IM_LO;
    localparam logic [WORD_W-1:0] SR_FD_ONLY   = WORD_W'(1) << SR_FD_BIT;

    // request slots, index 0 has the highest rank
    localparam int SLOT_POR  = 0;
    localparam int SLOT_MHIT = 1;
    localparam int SLOT_MRST = 2;
    localparam int SLOT_EXC  = 3;
    localparam int SLOT_TLB  = 4;
    localparam int SLOT_TRAP = 5;
    localparam int SLOT_IRQ  = 6;
    localparam int NUM_SLOTS = 7;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_POR,
        EV_MHIT,
        EV_MRST,
        EV_EXC,
        EV_TLB,
        EV_TRAP,
        EV_IRQ
    } entry_ev_e;

endpackage

// File: rtl/exc_req_arb.sv
`timescale 1ns/1ps
module exc_req_arb #(
    parameter int N = 7
) (
    input  logic [N-1:0] req_vec,
    output logic [N-1:0] grant
);
    // slot 0 wins over every higher-numbered slot
    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_rank
            if (gi == 0) begin : g_top
                assign grant[gi] = req_vec[gi];
            end else begin : g_rest
                assign grant[gi] = req_vec[gi] & ~(|req_vec[gi-1:0]);
            end
        end
    endgenerate
endmodule

// File: rtl/exc_sr_shaper.sv
`timescale 1ns/1ps
module exc_sr_shaper
    import exc_entry_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] cur_sr,
    output logic [W-1:0] sr_reset,
    output logic [W-1:0] sr_entry,
    output logic [W-1:0] sr_saved
);
    logic [W-1:0] raised;

    always_comb begin
        raised   = cur_sr | W'(SR_ENTRY_SET);
        sr_entry = raised & W'(SR_IMPL_MASK);
        sr_reset = (raised | W'(SR_IMASK_ALL)) & ~W'(SR_FD_ONLY) & W'(SR_IMPL_MASK);
        sr_saved = cur_sr & W'(SR_IMPL_MASK);
    end
endmodule

// File: rtl/exc_cause_fmt.sv
`timescale 1ns/1ps
module exc_cause_fmt #(
    parameter int W        = 32,
    parameter int IMM_W    = 8,
    parameter int PAGE_LSB = 10
) (
    input  logic [IMM_W-1:0] trap_imm,
    input  logic [W-1:0]     fault_addr,
    input  logic [W-1:0]     cur_pteh,
    output logic [W-1:0]     tra_val,
    output logic [W-1:0]     pteh_val
);
    localparam logic [W-1:0] KEEP_MASK = (W'(1) << PAGE_LSB) - W'(1);

    always_comb begin
        tra_val  = W'(trap_imm) << 2;
        pteh_val = (cur_pteh & KEEP_MASK) | (fault_addr & ~KEEP_MASK);
    end
endmodule

// File: rtl/exc_entry_seq.sv
`timescale 1ns/1ps
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int                CODE_W     = 12,
    parameter int                IMM_W      = 8,
    parameter int                PAGE_LSB   = 10,
    parameter logic [31:0]       RESET_PC   = 32'hA000_0000,
    parameter logic [31:0]       FPSCR_INIT = 32'h0004_0001,
    parameter logic [31:0]       SR_POR     = 32'h7000_00F0,
    parameter logic [31:0]       OFS_EXC    = 32'h0000_0100,
    parameter logic [31:0]       OFS_TLB    = 32'h0000_0400,
    parameter logic [31:0]       OFS_IRQ    = 32'h0000_0600,
    parameter logic [CODE_W-1:0] CODE_POR   = 12'h000,
    parameter logic [CODE_W-1:0] CODE_MRST  = 12'h020,
    parameter logic [CODE_W-1:0] CODE_MHIT  = 12'h140,
    parameter logic [CODE_W-1:0] CODE_TRAP  = 12'h160
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_req,
    input  logic              mhit_req,
    input  logic              mrst_req,
    input  logic              exc_req,
    input  logic              tlb_req,
    input  logic              trap_req,
    input  logic              irq_req,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [CODE_W-1:0] tlb_code,
    input  logic [CODE_W-1:0] irq_code,
    input  logic [IMM_W-1:0]  trap_imm,
    input  logic [31:0]       cur_pc,
    input  logic [31:0]       cur_sr,
    input  logic [31:0]       cur_r15,
    input  logic [31:0]       cur_vbr,
    input  logic [31:0]       cur_pteh,
    input  logic [31:0]       fault_addr,
    output logic              pc_we,
    output logic [31:0]       pc_o,
    output logic [31:0]       npc_o,
    output logic              dslot_clr,
    output logic              sr_we,
    output logic [31:0]       sr_o,
    output logic              ssave_we,
    output logic [31:0]       spc_o,
    output logic [31:0]       ssr_o,
    output logic [31:0]       sgr_o,
    output logic              vbr_clr,
    output logic              fpscr_we,
    output logic [31:0]       fpscr_o,
    output logic              expevt_we,
    output logic [CODE_W-1:0] expevt_o,
    output logic              intevt_we,
    output logic [CODE_W-1:0] intevt_o,
    output logic              tra_we,
    output logic [31:0]       tra_o,
    output logic              tea_we,
    output logic [31:0]       tea_o,
    output logic              pteh_we,
    output logic [31:0]       pteh_o
);
    localparam int W = 32;

    typedef struct packed {
        logic              pc_we;
        logic [W-1:0]      pc;
        logic [W-1:0]      npc;
        logic              dslot_clr;
        logic              sr_we;
        logic [W-1:0]      sr;
        logic              ssave_we;
        logic [W-1:0]      spc;
        logic [W-1:0]      ssr;
        logic [W-1:0]      sgr;
        logic              vbr_clr;
        logic              fpscr_we;
        logic [W-1:0]      fpscr;
        logic              expevt_we;
        logic [CODE_W-1:0] expevt;
        logic              intevt_we;
        logic [CODE_W-1:0] intevt;
        logic              tra_we;
        logic [W-1:0]      tra;
        logic              tea_we;
        logic [W-1:0]      tea;
        logic              pteh_we;
        logic [W-1:0]      pteh;
    } upd_t;

    // ---------------- request ranking ----------------
    logic                 bl_set;
    logic                 exc_to_reset;
    logic [NUM_SLOTS-1:0] req_vec;
    logic [NUM_SLOTS-1:0] grant;
    entry_ev_e            ev;

    assign bl_set       = cur_sr[SR_BL_BIT];
    assign exc_to_reset = exc_req & bl_set;

    always_comb begin
        req_vec            = '0;
        req_vec[SLOT_POR]  = por_req;
        req_vec[SLOT_MHIT] = mhit_req;
        req_vec[SLOT_MRST] = mrst_req | exc_to_reset;
        req_vec[SLOT_EXC]  = exc_req & ~bl_set;
        req_vec[SLOT_TLB]  = tlb_req;
        req_vec[SLOT_TRAP] = trap_req;
        req_vec[SLOT_IRQ]  = irq_req;
    end

    exc_req_arb #(.N(NUM_SLOTS)) u_arb (
        .req_vec (req_vec),
        .grant   (grant)
    );

    always_comb begin
        ev = EV_NONE;
        if      (grant[SLOT_POR])  ev = EV_POR;
        else if (grant[SLOT_MHIT]) ev = EV_MHIT;
        else if (grant[SLOT_MRST]) ev = EV_MRST;
        else if (grant[SLOT_EXC])  ev = EV_EXC;
        else if (grant[SLOT_TLB])  ev = EV_TLB;
        else if (grant[SLOT_TRAP]) ev = EV_TRAP;
        else if (grant[SLOT_IRQ])  ev = EV_IRQ;
    end

    // ---------------- value shaping ----------------
    logic [W-1:0] sr_reset_v, sr_entry_v, sr_saved_v;
    logic [W-1:0] tra_v, pteh_v;

    exc_sr_shaper #(.W(W)) u_sr (
        .cur_sr   (cur_sr),
        .sr_reset (sr_reset_v),
        .sr_entry (sr_entry_v),
        .sr_saved (sr_saved_v)
    );

    exc_cause_fmt #(.W(W), .IMM_W(IMM_W), .PAGE_LSB(PAGE_LSB)) u_cause (
        .trap_imm   (trap_imm),
        .fault_addr (fault_addr),
        .cur_pteh   (cur_pteh),
        .tra_val    (tra_v),
        .pteh_val   (pteh_v)
    );

    // ---------------- next-state computation ----------------
    upd_t         upd_d, upd_q;
    logic         is_reset, is_entry, is_fault_page;
    logic [W-1:0] vec_ofs;

    always_comb begin
        is_reset      = (ev == EV_POR) || (ev == EV_MHIT) || (ev == EV_MRST);
        is_entry      = (ev == EV_EXC) || (ev == EV_TLB) ||
                        (ev == EV_TRAP) || (ev == EV_IRQ);
        is_fault_page = (ev == EV_MHIT) || (ev == EV_TLB);

        unique case (ev)
            EV_TLB:  vec_ofs = OFS_TLB;
            EV_IRQ:  vec_ofs = OFS_IRQ;
            default: vec_ofs = OFS_EXC;
        endcase

        upd_d = '0;

        if (is_reset) begin
            upd_d.pc_we     = 1'b1;
            upd_d.pc        = RESET_PC;
            upd_d.npc       = RESET_PC + W'(2);
            upd_d.dslot_clr = 1'b1;
            upd_d.sr_we     = 1'b1;
            upd_d.sr        = (ev == EV_POR) ? SR_POR : sr_reset_v;
            upd_d.vbr_clr   = 1'b1;
            upd_d.expevt_we = 1'b1;
        end

        if (is_entry) begin
            upd_d.pc_we     = 1'b1;
            upd_d.pc        = cur_vbr + vec_ofs;
            upd_d.npc       = cur_vbr + vec_ofs + W'(2);
            upd_d.dslot_clr = 1'b1;
            upd_d.sr_we     = 1'b1;
            upd_d.sr        = sr_entry_v;
            upd_d.ssave_we  = 1'b1;
            upd_d.spc       = cur_pc;
            upd_d.ssr       = sr_saved_v;
            upd_d.sgr       = cur_r15;
            upd_d.expevt_we = (ev != EV_IRQ);
        end

        if (is_fault_page) begin
            upd_d.tea_we  = 1'b1;
            upd_d.tea     = fault_addr;
            upd_d.pteh_we = 1'b1;
            upd_d.pteh    = pteh_v;
        end

        unique case (ev)
            EV_POR: begin
                upd_d.fpscr_we = 1'b1;
                upd_d.fpscr    = FPSCR_INIT;
                upd_d.expevt   = CODE_POR;
            end
            EV_MHIT: upd_d.expevt = CODE_MHIT;
            EV_MRST: upd_d.expevt = CODE_MRST;
            EV_EXC:  upd_d.expevt = exc_code;
            EV_TLB:  upd_d.expevt = tlb_code;
            EV_TRAP: begin
                upd_d.expevt = CODE_TRAP;
                upd_d.tra_we = 1'b1;
                upd_d.tra    = tra_v;
            end
            EV_IRQ: begin
                upd_d.intevt_we = 1'b1;
                upd_d.intevt    = irq_code;
            end
            default: ;
        endcase
    end

    // ---------------- state ----------------
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_q           <= '0;
            upd_q.pc_we     <= 1'b1;
            upd_q.pc        <= RESET_PC;
            upd_q.npc       <= RESET_PC + W'(2);
            upd_q.dslot_clr <= 1'b1;
            upd_q.sr_we     <= 1'b1;
            upd_q.sr        <= SR_POR;
            upd_q.vbr_clr   <= 1'b1;
            upd_q.fpscr_we  <= 1'b1;
            upd_q.fpscr     <= FPSCR_INIT;
            upd_q.expevt_we <= 1'b1;
            upd_q.expevt    <= CODE_POR;
            armed_q         <= 1'b0;
        end else begin
            upd_q   <= upd_d;
            armed_q <= 1'b1;
        end
    end

    assign pc_we     = upd_q.pc_we;
    assign pc_o      = upd_q.pc;
    assign npc_o     = upd_q.npc;
    assign dslot_clr = upd_q.dslot_clr;
    assign sr_we     = upd_q.sr_we;
    assign sr_o      = upd_q.sr;
    assign ssave_we  = upd_q.ssave_we;
    assign spc_o     = upd_q.spc;
    assign ssr_o     = upd_q.ssr;
    assign sgr_o     = upd_q.sgr;
    assign vbr_clr   = upd_q.vbr_clr;
    assign fpscr_we  = upd_q.fpscr_we;
    assign fpscr_o   = upd_q.fpscr;
    assign expevt_we = upd_q.expevt_we;
    assign expevt_o  = upd_q.expevt;
    assign intevt_we = upd_q.intevt_we;
    assign intevt_o  = upd_q.intevt;
    assign tra_we    = upd_q.tra_we;
    assign tra_o     = upd_q.tra;
    assign tea_we    = upd_q.tea_we;
    assign tea_o     = upd_q.tea;
    assign pteh_we   = upd_q.pteh_we;
    assign pteh_o    = upd_q.pteh;

    // ---------------- assertions ----------------
    a_r5_npc_step: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |-> (npc_o == pc_o + 32'd2));

    a_r4_entry_forces_priv: assert property (@(posedge clk) disable iff (!rst_n)
        ssave_we |-> (sr_we && sr_o[SR_MD_BIT] && sr_o[SR_BL_BIT] && sr_o[SR_RB_BIT]));

    a_r8_irq_no_expevt: assert property (@(posedge clk) disable iff (!rst_n)
        intevt_we |-> (!expevt_we && ssave_we));

    a_r3_blocked_exc_resets: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(exc_req && cur_sr[SR_BL_BIT]))
            |-> (pc_o == RESET_PC && !ssave_we && vbr_clr));

    a_r7_pteh_page: assert property (@(posedge clk) disable iff (!rst_n)
        pteh_we |-> (tea_we && pteh_o[31:PAGE_LSB] == tea_o[31:PAGE_LSB]));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(!(por_req || mhit_req || mrst_req || exc_req ||
                            tlb_req || trap_req || irq_req)))
            |-> (!pc_we && !sr_we && !expevt_we && !intevt_we));

    a_r11_sr_mask: assert property (@(posedge clk) disable iff (!rst_n)
        ((sr_o & ~SR_IMPL_MASK) == 32'd0) && ((ssr_o & ~SR_IMPL_MASK) == 32'd0));

    a_r2_reset_no_save: assert property (@(posedge clk) disable iff (!rst_n)
        vbr_clr |-> (pc_o == RESET_PC && !ssave_we));

    a_r12_dslot_with_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(por_req || exc_req || irq_req)) |-> (dslot_clr && pc_we));

endmodule

// File: tb/exc_entry_seq_tb_top.sv
`timescale 1ns/1ps
module exc_entry_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_req = 0, mhit_req = 0, mrst_req = 0, exc_req = 0;
    logic        tlb_req = 0, trap_req = 0, irq_req = 0;
    logic [11:0] exc_code = 12'h1E0, tlb_code = 12'h040, irq_code = 12'h320;
    logic [7:0]  trap_imm = 8'hA5;
    logic [31:0] cur_pc = 32'h8C00_1234, cur_sr = '0, cur_r15 = 32'h8CFF_0000;
    logic [31:0] cur_vbr = '0, cur_pteh = 32'h1111_12F5, fault_addr = 32'h7654_3ABC;

    logic        pc_we, dslot_clr, sr_we, ssave_we, vbr_clr, fpscr_we;
    logic        expevt_we, intevt_we, tra_we, tea_we, pteh_we;
    logic [31:0] pc_o, npc_o, sr_o, spc_o, ssr_o, sgr_o, fpscr_o, tra_o, tea_o, pteh_o;
    logic [11:0] expevt_o, intevt_o;

    always #2.5 clk = ~clk;

    exc_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .por_req(por_req), .mhit_req(mhit_req), .mrst_req(mrst_req),
        .exc_req(exc_req), .tlb_req(tlb_req), .trap_req(trap_req), .irq_req(irq_req),
        .exc_code(exc_code), .tlb_code(tlb_code), .irq_code(irq_code),
        .trap_imm(trap_imm), .cur_pc(cur_pc), .cur_sr(cur_sr), .cur_r15(cur_r15),
        .cur_vbr(cur_vbr), .cur_pteh(cur_pteh), .fault_addr(fault_addr),
        .pc_we(pc_we), .pc_o(pc_o), .npc_o(npc_o), .dslot_clr(dslot_clr),
        .sr_we(sr_we), .sr_o(sr_o), .ssave_we(ssave_we), .spc_o(spc_o),
        .ssr_o(ssr_o), .sgr_o(sgr_o), .vbr_clr(vbr_clr),
        .fpscr_we(fpscr_we), .fpscr_o(fpscr_o),
        .expevt_we(expevt_we), .expevt_o(expevt_o),
        .intevt_we(intevt_we), .intevt_o(intevt_o),
        .tra_we(tra_we), .tra_o(tra_o), .tea_we(tea_we), .tea_o(tea_o),
        .pteh_we(pteh_we), .pteh_o(pteh_o)
    );

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // req bits: [6]=por [5]=mhit [4]=mrst [3]=exc [2]=tlb [1]=trap [0]=irq
    task automatic fire(logic [6:0] req, logic [31:0] sr, logic [31:0] vbr);
        @(negedge clk);
        {por_req, mhit_req, mrst_req, exc_req, tlb_req, trap_req, irq_req} = req;
        cur_sr  = sr;
        cur_vbr = vbr;
        @(posedge clk);
        #1;
    endtask

    task automatic idle;
        @(negedge clk);
        {por_req, mhit_req, mrst_req, exc_req, tlb_req, trap_req, irq_req} = '0;
        @(posedge clk);
        #1;
    endtask

    typedef struct packed {
        logic [6:0]  req;
        logic [31:0] sr;
        logic [31:0] vbr;
        logic [31:0] pc;
        logic [31:0] sr_exp;
        logic        ev_we;
        logic [11:0] ev;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        // R5 general exception vector
        '{7'b0001000, 32'h0000_00F0, 32'h8C00_0000, 32'h8C00_0100, 32'h7000_00F0, 1'b1, 12'h1E0, 8'd5},
        // R5 trap vector
        '{7'b0000010, 32'h0000_0001, 32'h8000_0000, 32'h8000_0100, 32'h7000_0001, 1'b1, 12'h160, 8'd5},
        // R5 TLB vector, FD kept on entry
        '{7'b0000100, 32'h0000_8300, 32'h8C01_0000, 32'h8C01_0400, 32'h7000_8300, 1'b1, 12'h040, 8'd5},
        // R8 interrupt vector, no exception event write
        '{7'b0000001, 32'h4000_0000, 32'h8C00_0000, 32'h8C00_0600, 32'h7000_0000, 1'b0, 12'h000, 8'd8},
        // R3 exception with BL set becomes manual reset, FD cleared
        '{7'b0001000, 32'h1000_8002, 32'h8C00_0000, 32'hA000_0000, 32'h7000_00F2, 1'b1, 12'h020, 8'd3},
        // R2 manual reset from all-ones SR
        '{7'b0010000, 32'hFFFF_FFFF, 32'h8C00_0000, 32'hA000_0000, 32'h7000_03F3, 1'b1, 12'h020, 8'd2},
        // R2 multiple-hit reset
        '{7'b0100000, 32'h0000_0000, 32'h8C00_0000, 32'hA000_0000, 32'h7000_00F0, 1'b1, 12'h140, 8'd2},
        // R1 power-on request
        '{7'b1000000, 32'h1234_5678, 32'h8C00_0000, 32'hA000_0000, 32'h7000_00F0, 1'b1, 12'h000, 8'd1},
        // R9 exception beats trap and interrupt
        '{7'b0001011, 32'h0000_0000, 32'h0000_1000, 32'h0000_1100, 32'h7000_0000, 1'b1, 12'h1E0, 8'd9},
        // R9 trap beats interrupt
        '{7'b0000011, 32'h0000_0000, 32'h0000_2000, 32'h0000_2100, 32'h7000_0000, 1'b1, 12'h160, 8'd9},
        // R9 TLB beats trap
        '{7'b0000110, 32'h0000_0000, 32'h0000_3000, 32'h0000_3400, 32'h7000_0000, 1'b1, 12'h040, 8'd9},
        // R9 manual reset beats exception and interrupt
        '{7'b0011001, 32'h0000_0000, 32'h0000_4000, 32'hA000_0000, 32'h7000_00F0, 1'b1, 12'h020, 8'd9},
        // R9 power-on beats the other resets
        '{7'b1110000, 32'h0000_0000, 32'h0000_5000, 32'hA000_0000, 32'h7000_00F0, 1'b1, 12'h000, 8'd9},
        // R9 multiple-hit beats manual reset
        '{7'b0110000, 32'h0000_0000, 32'h0000_6000, 32'hA000_0000, 32'h7000_00F0, 1'b1, 12'h140, 8'd9},
        // R11 unimplemented SR bits dropped on entry
        '{7'b0001000, 32'h0F0F_0C0C, 32'h0000_7000, 32'h0000_7100, 32'h7000_0000, 1'b1, 12'h1E0, 8'd11}
    };

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R10 watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: power-on image held while in reset
        #7;
        chk("R1", "pc_o", pc_o, 32'hA000_0000);
        chk("R1", "npc_o", npc_o, 32'hA000_0002);
        chk("R1", "sr_o", sr_o, 32'h7000_00F0);
        chk("R1", "vbr_clr", {31'd0, vbr_clr}, 32'd1);
        chk("R1", "fpscr", {fpscr_we, fpscr_o[30:0]}, 32'h8004_0001);
        chk("R1", "expevt", {19'd0, expevt_we, expevt_o}, 32'h0000_1000);
        chk("R1", "ssave_we", {31'd0, ssave_we}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: quiet after reset release
        idle();
        chk("R10", "strobes idle",
            {26'd0, pc_we, sr_we, expevt_we, intevt_we, fpscr_we, ssave_we}, 32'd0);

        // table walk (R2 R3 R5 R8 R9 R11)
        for (int i = 0; i < NV; i++) begin
            string t;
            t = $sformatf("R%0d", VECS[i].rq);
            fire(VECS[i].req, VECS[i].sr, VECS[i].vbr);
            chk(t, $sformatf("vec%0d pc_o", i), pc_o, VECS[i].pc);
            chk(t, $sformatf("vec%0d npc_o", i), npc_o, VECS[i].pc + 32'd2);
            chk(t, $sformatf("vec%0d sr_o", i), sr_o, VECS[i].sr_exp);
            chk(t, $sformatf("vec%0d expevt_we", i), {31'd0, expevt_we}, {31'd0, VECS[i].ev_we});
            if (VECS[i].ev_we)
                chk(t, $sformatf("vec%0d expevt_o", i), {20'd0, expevt_o}, {20'd0, VECS[i].ev});
        end

        // R6 R4 R12: trap operand and saved state
        fire(7'b0000010, 32'h0000_0303, 32'h8C00_0000);
        chk("R6", "tra_o", tra_o, 32'h0000_0294);
        chk("R6", "tra_we", {31'd0, tra_we}, 32'd1);
        chk("R4", "spc_o", spc_o, 32'h8C00_1234);
        chk("R4", "sgr_o", sgr_o, 32'h8CFF_0000);
        chk("R4", "ssr_o", ssr_o, 32'h0000_0303);
        chk("R12", "dslot_clr", {31'd0, dslot_clr}, 32'd1);

        // R7: TLB exception page merge
        fire(7'b0000100, 32'h0000_0000, 32'h8C00_0000);
        chk("R7", "tea_o", tea_o, 32'h7654_3ABC);
        chk("R7", "pteh_o", pteh_o, 32'h7654_3AF5);
        chk("R7", "ssave_we", {31'd0, ssave_we}, 32'd1);

        // R7 R2: multiple-hit writes fault page but saves nothing
        fire(7'b0100000, 32'h0000_0000, 32'h8C00_0000);
        chk("R7", "mhit tea_o", tea_o, 32'h7654_3ABC);
        chk("R7", "mhit pteh_o", pteh_o, 32'h7654_3AF5);
        chk("R2", "mhit ssave_we", {31'd0, ssave_we}, 32'd0);
        chk("R2", "mhit vbr_clr", {31'd0, vbr_clr}, 32'd1);

        // R8: interrupt code goes to its own register
        fire(7'b0000001, 32'h0000_0000, 32'h8C00_0000);
        chk("R8", "intevt_o", {20'd0, intevt_o}, 32'h0000_0320);
        chk("R8", "intevt_we", {31'd0, intevt_we}, 32'd1);
        chk("R8", "expevt_we", {31'd0, expevt_we}, 32'd0);

        // R11: saved SR masked, new SR masked
        fire(7'b0001000, 32'hEFFF_FFFF, 32'h0000_0000);
        chk("R11", "ssr_o", ssr_o, 32'h6000_83F3);
        chk("R11", "sr_o", sr_o, 32'h7000_83F3);

        // R3: blocked exception saves nothing and clears VBR
        fire(7'b0001000, 32'h1000_0000, 32'h8C00_0000);
        chk("R3", "ssave_we", {31'd0, ssave_we}, 32'd0);
        chk("R3", "vbr_clr", {31'd0, vbr_clr}, 32'd1);

        // R10: back-to-back requests, then quiet
        fire(7'b0001000, 32'h0000_0000, 32'h0000_8000);
        chk("R10", "b2b first pc_o", pc_o, 32'h0000_8100);
        fire(7'b0000001, 32'h0000_0000, 32'h0000_8000);
        chk("R10", "b2b second pc_o", pc_o, 32'h0000_8600);
        idle();
        chk("R10", "quiet pc_we", {31'd0, pc_we}, 32'd0);
        chk("R10", "quiet tra/tea/pteh", {29'd0, tra_we, tea_we, pteh_we}, 32'd0);

        // R1: power-on request mid-run reloads FP control
        fire(7'b1000000, 32'h0000_0000, 32'h8C00_0000);
        chk("R1", "fpscr_o", fpscr_o, 32'h0004_0001);
        chk("R1", "fpscr_we", {31'd0, fpscr_we}, 32'd1);
        idle();
        chk("R10", "fpscr_we idle", {31'd0, fpscr_we}, 32'd0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule